// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block tracks one atomic reservation for one hardware thread. A load-reserve request records the physical address and the access size, and marks the reservation live. Writes by other agents arrive on a snoop port. A snoop to exactly the reserved address kills the reservation.

Each store-conditional request is judged against the reservation held at that moment. The block reports whether the store may go to memory. It also produces a 4-bit condition code that carries the summary-overflow bit, and it flags the architecturally undefined case separately. It keeps a count of consecutive failures and gives a one-cycle warning at each nonzero multiple of a programmable period, so that a livelock can be seen.

All results are registered. They appear in the cycle after the store-conditional request is presented.

Top module: `resv_monitor`

## Requirements
- R1: A load-reserve (`lrValid`) records `lrAddr` and `lrSize` and makes the reservation live. A later load-reserve replaces the earlier one completely. Size code: 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes, 2'b11 = 8 bytes.
- R2: A snoop whose address equals the reserved address kills a live reservation. A snoop to any other address leaves the reservation untouched.
- R3: A store-conditional passes only when the reservation is live and both its size code and its address equal the recorded ones. Its results are visible one clock after the request.
- R4: A live reservation with a size or address mismatch, where the store address agrees with the reserved address in all bits from bit 16 upward (the same 64 KiB region), raises `undefFlag`. This case always resolves as a failure.
- R5: Every store-conditional, whether it passes or fails, leaves the reservation dead afterwards. The one exception is a load-reserve in the same cycle, which installs a new reservation.
- R6: `condValid` pulses for one cycle with each result. `condResult` is {2'b00, pass, scOverflow}, so a pass gives 4'b0010 or 4'b0011 and a failure gives 4'b0000 or 4'b0001.
- R7: `storeEn` is high only for a passing store-conditional, and never for a failure or an undefined case.
- R8: `failCount` increments on each failing store-conditional and returns to zero on each passing one.
- R9: `livelockWarn` pulses for one cycle, together with the result, when `failCount` reaches a nonzero multiple of `WARN_PERIOD`.
- R10: When a matching snoop and a store-conditional arrive in the same cycle, the snoop wins. The store-conditional fails and does not raise `undefFlag`.
- R11: Synchronous reset kills the reservation, zeroes `failCount`, and clears all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lrValid | input | 1 | Load-reserve request |
| lrAddr | input | ADDR_W | Load-reserve physical address |
| lrSize | input | 2 | Load-reserve size code |
| scValid | input | 1 | Store-conditional request |
| scAddr | input | ADDR_W | Store-conditional physical address |
| scSize | input | 2 | Store-conditional size code |
| scOverflow | input | 1 | Current summary-overflow bit |
| snoopValid | input | 1 | Remote write observed |
| snoopAddr | input | ADDR_W | Address of the remote write |
| storeEn | output | 1 | Issue the conditional store to memory |
| condValid | output | 1 | Result valid pulse |
| condResult | output | 4 | Condition code for the store-conditional |
| undefFlag | output | 1 | Mismatch inside the reserved 64 KiB region |
| failCount | output | CNT_W | Consecutive failure count |
| livelockWarn | output | 1 | Failure count reached a multiple of WARN_PERIOD |

## Verification
A snoop that kills the reservation and a store-conditional that consumes it can land in the same clock. The bench drives both requests in one cycle after a valid load-reserve, with the snoop address equal to the reserved one. It then expects a plain failure: no store, a condition code of 4'b0000, `undefFlag` low, and an incremented failure count. A second case sends a snoop to a neighbouring address before the store-conditional, and expects that store-conditional to still pass.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes
  typedef logic [1:0] sizeCode_t;

  // Strobes from the decision logic to the state holder
  typedef struct packed {
    logic setRsv;   // install a new reservation
    logic clrRsv;   // kill the reservation
    logic scPass;   // store-conditional succeeds
    logic scFail;   // store-conditional fails
    logic scUndef;  // failure falls in the undefined case
  } resvStrobe_t;

endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lrValid,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  sizeCode_t         scSize,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              rsvValid,
  input  sizeCode_t         rsvSize,
  input  logic [ADDR_W-1:0] rsvAddr,
  output resvStrobe_t       strb
);

  localparam int REGION_W = ADDR_W - REGION_LSB;

  logic snoopHit;
  logic liveRsv;
  logic exactMatch;
  logic sameRegion;

  always_comb begin
    snoopHit   = snoopValid && rsvValid && (snoopAddr == rsvAddr);
    // The snoop takes priority over a store-conditional in the same cycle
    liveRsv    = rsvValid && !snoopHit;
    exactMatch = (scSize == rsvSize) && (scAddr == rsvAddr);
    sameRegion = (scAddr[ADDR_W-1 -: REGION_W] == rsvAddr[ADDR_W-1 -: REGION_W]);

    strb.setRsv  = lrValid;
    strb.clrRsv  = scValid || snoopHit;
    strb.scPass  = scValid && liveRsv && exactMatch;
    strb.scFail  = scValid && !(liveRsv && exactMatch);
    strb.scUndef = scValid && liveRsv && !exactMatch && sameRegion;
  end

  // R10: a matching snoop in the same cycle never lets the store through
  assert_snoop_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (scValid && snoopValid && rsvValid && snoopAddr == rsvAddr) |-> (!strb.scPass && !strb.scUndef));

  // R3: at most one verdict per request
  assert_one_verdict_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.scPass, strb.scFail}));

  // R4: the undefined case is a kind of failure
  assert_undef_fails_R4: assert property (@(posedge clk) disable iff (rst)
    strb.scUndef |-> strb.scFail);

endmodule

// File: rtl/resv_dpath.sv
module resv_dpath
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  resvStrobe_t       strb,
  input  logic [ADDR_W-1:0] lrAddr,
  input  sizeCode_t         lrSize,
  input  logic              scOverflow,
  output logic              rsvValid,
  output sizeCode_t         rsvSize,
  output logic [ADDR_W-1:0] rsvAddr,
  output logic              storeEn,
  output logic              condValid,
  output logic [3:0]        condResult,
  output logic              undefFlag,
  output logic [CNT_W-1:0]  failCount,
  output logic              livelockWarn
);

  localparam int PER_W = $clog2(WARN_PERIOD + 1);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(WARN_PERIOD - 1);

  logic [PER_W-1:0] periodCnt;

  // Reservation state: a new load-reserve beats any clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rsvValid <= 1'b0;
      rsvSize  <= '0;
      rsvAddr  <= '0;
    end else if (strb.setRsv) begin
      rsvValid <= 1'b1;
      rsvSize  <= lrSize;
      rsvAddr  <= lrAddr;
    end else if (strb.clrRsv) begin
      rsvValid <= 1'b0;
    end
  end

  // Registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      storeEn    <= 1'b0;
      condValid  <= 1'b0;
      condResult <= '0;
      undefFlag  <= 1'b0;
    end else begin
      storeEn    <= strb.scPass;
      condValid  <= strb.scPass || strb.scFail;
      condResult <= (strb.scPass || strb.scFail) ? {2'b00, strb.scPass, scOverflow} : 4'b0000;
      undefFlag  <= strb.scUndef;
    end
  end

  // Consecutive failures and the livelock warning
  always_ff @(posedge clk) begin
    if (rst) begin
      failCount    <= '0;
      periodCnt    <= '0;
      livelockWarn <= 1'b0;
    end else begin
      livelockWarn <= 1'b0;
      if (strb.scPass) begin
        failCount <= '0;
        periodCnt <= '0;
      end else if (strb.scFail) begin
        failCount <= failCount + 1'b1;
        if (periodCnt == PER_LAST) begin
          periodCnt    <= '0;
          livelockWarn <= 1'b1;
        end else begin
          periodCnt <= periodCnt + 1'b1;
        end
      end
    end
  end

  // R7: a store is only ever issued with a success code
  assert_store_on_pass_R7: assert property (@(posedge clk) disable iff (rst)
    storeEn |-> (condValid && condResult[1]));

  // R4: an undefined case never stores
  assert_undef_nostore_R4: assert property (@(posedge clk) disable iff (rst)
    undefFlag |-> !storeEn);

  // R8: a pass leaves the counter at zero
  assert_count_clear_R8: assert property (@(posedge clk) disable iff (rst)
    storeEn |-> (failCount == '0));

  // R9: a warning only comes with a nonzero count and a failed result
  assert_warn_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    livelockWarn |-> (failCount != '0 && condValid && !condResult[1]));

  // R5: a consumed reservation is dead unless reinstalled
  assert_sc_clears_R5: assert property (@(posedge clk) disable iff (rst)
    ((strb.scPass || strb.scFail) && !strb.setRsv) |=> !rsvValid);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lrValid,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic [1:0]        lrSize,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [1:0]        scSize,
  input  logic              scOverflow,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              storeEn,
  output logic              condValid,
  output logic [3:0]        condResult,
  output logic              undefFlag,
  output logic [CNT_W-1:0]  failCount,
  output logic              livelockWarn
);

  localparam int REGION_LSB = 16;

  resvStrobe_t       strb;
  logic              rsvValid;
  sizeCode_t         rsvSize;
  logic [ADDR_W-1:0] rsvAddr;

  resv_ctrl #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) uCtrl (
    .clk(clk), .rst(rst),
    .lrValid(lrValid), .scValid(scValid), .scAddr(scAddr), .scSize(scSize),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .rsvValid(rsvValid), .rsvSize(rsvSize), .rsvAddr(rsvAddr),
    .strb(strb)
  );

  resv_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) uDpath (
    .clk(clk), .rst(rst), .strb(strb),
    .lrAddr(lrAddr), .lrSize(lrSize), .scOverflow(scOverflow),
    .rsvValid(rsvValid), .rsvSize(rsvSize), .rsvAddr(rsvAddr),
    .storeEn(storeEn), .condValid(condValid), .condResult(condResult),
    .undefFlag(undefFlag), .failCount(failCount), .livelockWarn(livelockWarn)
  );

endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;

  localparam int AW = 32;
  localparam int CW = 32;
  localparam int PERIOD = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          lrValid, scValid, scOverflow, snoopValid;
  logic [AW-1:0] lrAddr, scAddr, snoopAddr;
  logic [1:0]    lrSize, scSize;
  logic          storeEn, condValid, undefFlag, livelockWarn;
  logic [3:0]    condResult;
  logic [CW-1:0] failCount;

  int checks = 0;
  int fails = 0;
  int expFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  resv_monitor #(.ADDR_W(AW), .CNT_W(CW), .WARN_PERIOD(PERIOD)) uut (
    .clk(clk), .rst(rst),
    .lrValid(lrValid), .lrAddr(lrAddr), .lrSize(lrSize),
    .scValid(scValid), .scAddr(scAddr), .scSize(scSize), .scOverflow(scOverflow),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .storeEn(storeEn), .condValid(condValid), .condResult(condResult),
    .undefFlag(undefFlag), .failCount(failCount), .livelockWarn(livelockWarn)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lrValid = 0; scValid = 0; snoopValid = 0; scOverflow = 0;
    lrAddr = '0; scAddr = '0; snoopAddr = '0; lrSize = '0; scSize = '0;
  endtask

  task automatic loadRes(input logic [AW-1:0] a, input logic [1:0] s);
    @(negedge clk);
    lrValid = 1; lrAddr = a; lrSize = s;
    @(negedge clk);
    idle();
  endtask

  task automatic snoop(input logic [AW-1:0] a);
    @(negedge clk);
    snoopValid = 1; snoopAddr = a;
    @(negedge clk);
    idle();
  endtask

  // Apply a store-conditional (optionally with a snoop) and check the results one clock later
  task automatic storeCond(input string req, input logic [AW-1:0] a, input logic [1:0] s,
                           input logic ovf, input bit withSnoop, input logic [AW-1:0] sa,
                           input bit expPass, input bit expUndef);
    bit expWarn;
    @(negedge clk);
    scValid = 1; scAddr = a; scSize = s; scOverflow = ovf;
    snoopValid = withSnoop; snoopAddr = sa;
    @(negedge clk);
    idle();
    if (expPass) expFail = 0; else expFail++;
    expWarn = !expPass && (expFail % PERIOD == 0);
    chk({req, " storeEn"}, storeEn, expPass);
    chk({req, " condValid"}, condValid, 1);
    chk({req, " condResult"}, condResult, {2'b00, expPass, ovf});
    chk({req, " undefFlag"}, undefFlag, expUndef);
    chk({req, " failCount R8"}, failCount, expFail);
    chk({req, " livelockWarn R9"}, livelockWarn, expWarn);
    @(negedge clk);
    chk({req, " condValid pulse R6"}, condValid, 0);
  endtask

  task automatic testReset();
    chk("R11 storeEn after reset", storeEn, 0);
    chk("R11 condValid after reset", condValid, 0);
    chk("R11 failCount after reset", failCount, 0);
    chk("R11 warn after reset", livelockWarn, 0);
  endtask

  task automatic testBasicPass();
    loadRes(32'h1000_0040, 2'b10);
    storeCond("R3 exact pass", 32'h1000_0040, 2'b10, 0, 0, '0, 1, 0);
    loadRes(32'h2000_0008, 2'b11);
    storeCond("R6 pass with overflow", 32'h2000_0008, 2'b11, 1, 0, '0, 1, 0);
  endtask

  task automatic testClearAfterSc();
    storeCond("R5 second sc after pass", 32'h2000_0008, 2'b11, 1, 0, '0, 0, 0);
    loadRes(32'h3000_0010, 2'b01);
    storeCond("R5 fail by size/region", 32'h3001_0010, 2'b01, 0, 0, '0, 0, 0);
    storeCond("R5 sc after failed sc", 32'h3000_0010, 2'b01, 0, 0, '0, 0, 0);
  endtask

  task automatic testUndef();
    loadRes(32'h1000_0040, 2'b10);
    storeCond("R4 size mismatch same region", 32'h1000_0040, 2'b01, 0, 0, '0, 0, 1);
    loadRes(32'h1000_0040, 2'b10);
    storeCond("R4 addr mismatch same region R7", 32'h1000_FFF0, 2'b10, 1, 0, '0, 0, 1);
    loadRes(32'h1000_0040, 2'b10);
    storeCond("R4 other region no undef", 32'h1001_0040, 2'b10, 0, 0, '0, 0, 0);
  endtask

  task automatic testSnoop();
    loadRes(32'h4000_0100, 2'b10);
    snoop(32'h4000_0100);
    storeCond("R2 matching snoop kills", 32'h4000_0100, 2'b10, 0, 0, '0, 0, 0);
    loadRes(32'h4000_0100, 2'b10);
    snoop(32'h4000_0104);
    storeCond("R2 other snoop ignored", 32'h4000_0100, 2'b10, 0, 0, '0, 1, 0);
    loadRes(32'h4000_0100, 2'b10);
    storeCond("R10 snoop with sc", 32'h4000_0100, 2'b10, 0, 1, 32'h4000_0100, 0, 0);
  endtask

  task automatic testOverwrite();
    loadRes(32'h0001_0000, 2'b00);
    loadRes(32'h0002_0000, 2'b11);
    storeCond("R1 old reservation replaced", 32'h0001_0000, 2'b00, 0, 0, '0, 0, 0);
    loadRes(32'h0001_0000, 2'b00);
    loadRes(32'h0002_0000, 2'b11);
    storeCond("R1 new reservation used", 32'h0002_0000, 2'b11, 0, 0, '0, 1, 0);
  endtask

  task automatic testLivelock();
    for (int i = 0; i < 9; i++)
      storeCond("R9 failure run", 32'h5000_0000, 2'b10, 0, 0, '0, 0, 0);
    loadRes(32'h5000_0000, 2'b10);
    storeCond("R8 pass clears count", 32'h5000_0000, 2'b10, 0, 0, '0, 1, 0);
  endtask

  task automatic testResetMid();
    storeCond("R11 pre-reset fail", 32'h6000_0000, 2'b10, 0, 0, '0, 0, 0);
    loadRes(32'h6000_0000, 2'b10);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    expFail = 0;
    chk("R11 failCount cleared", failCount, 0);
    storeCond("R11 reservation cleared", 32'h6000_0000, 2'b10, 0, 0, '0, 0, 0);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testBasicPass();
    testClearAfterSc();
    testUndef();
    testSnoop();
    testOverwrite();
    testLivelock();
    testResetMid();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule